// File: doc/BRIEF.md
# Transfer Byte Counter and Address Tracker

This block follows one data transfer on a peripheral bus. It holds a 24-bit count of the bytes still to move and a 32-bit address that names the next byte. A per-byte commit strobe from the data path fires only once a byte has actually crossed the bus. On each strobe the count drops by one and the address rises by one. Because the address moves only on committed bytes, it always names the exact byte after the last one that completed. Bytes that the data path has already fetched ahead of the bus do not move it.

Software sees both counters as byte registers, least significant byte first, on a small byte-wide register port. Two sticky status flags are kept. One marks that the count has run down to zero. The other marks that the count was stepped below zero and rolled over. Each flag is cleared by writing a 1 to it. An enable mask selects which flags drive a single registered interrupt line. A control bit wipes the count in one write.

Top module: `xfer_track`

Register offsets on `reg_addr`:

| Offset | Contents |
|---|---|
| 0x0 to 0x2 | Count bytes 0 to 2 |
| 0x4 to 0x7 | Address bytes 0 to 3 |
| 0x8 | Status (read) and clear (write) |
| 0x9 | Interrupt enable |
| 0xA | Control |

## Requirements
- R1: After reset, all of the following read 0 and `irq` is 0: the count, the address, the status register (offset 0x8) and the enable register (offset 0x9).
- R2: The count is read and written as bytes at offsets 0x0, 0x1 and 0x2, with the least significant byte at 0x0. A cycle with `xfer_commit` high and no count write or count clear lowers the count by exactly one, with borrow across bytes. With no commit, the count holds.
- R3: Status bit 0 (done) is set when a commit takes the count from 1 to 0.
- R4: Status bit 1 (wrap) is set when a commit steps a count of 0, which then becomes 0xFFFFFF. Done is not set by that step.
- R5: The address is read and written as bytes at offsets 0x4 to 0x7, with the least significant byte at 0x4. Each commit raises it by one with carry across bytes, unless an address byte is written in that cycle.
- R6: A write to offset 0x8 clears each status bit whose data bit is 1 and leaves a bit whose data bit is 0 unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R7: Writing offset 0xA with data bit 0 at 1 sets the count to 0. This takes priority over a commit in the same cycle, so neither a step nor a flag results. Offset 0xA reads 0.
- R8: Offset 0x9 bits [1:0] enable done and wrap respectively. `irq` equals the OR of status AND enable, registered once, so it follows a status or enable change by one cycle.
- R9: A write to a count byte in the same cycle as a commit has priority. The written byte takes the new data, the other count bytes keep their values, the count does not step and no flag is set. The address still steps unless an address byte is also written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| xfer_commit | input | 1 | One byte has completed on the bus |
| irq | output | 1 | Registered, masked interrupt |

## Verification
The assertions check on every cycle the one-step arithmetic of both counters, that the count holds without a commit, that the clear bit zeroes the count, and that the done and wrap flags set at the right counts. They also check that `irq` tracks the masked status one cycle late. Only the bench scenarios show the byte-lane layout of each register, and that a byte write to one counter leaves its other bytes alone. The same goes for the write-one-to-clear rule for each flag bit, set winning over clear in the same cycle, and the carry and borrow across byte boundaries.

// File: rtl/xfer_track_pkg.sv
package xfer_track_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_AW   = 4;
    localparam int N_FLAGS  = 2;

    localparam int OFS_CNT  = 0;
    localparam int OFS_ADR  = 4;
    localparam int OFS_STAT = 8;
    localparam int OFS_IEN  = 9;
    localparam int OFS_CTL  = 10;

    localparam int FLAG_DONE = 0;
    localparam int FLAG_WRAP = 1;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } reg_req_t;

    function automatic logic ofs_match(input logic [REG_AW-1:0] a, input int ofs);
        return a == REG_AW'(ofs);
    endfunction

endpackage

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
    import xfer_track_pkg::*;
#(
    parameter int W    = 24,
    parameter bit DOWN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W/8-1:0]    lane_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr,
    input  logic              step,
    output logic [W-1:0]      q,
    output logic              hit_zero,
    output logic              wrapped
);
    localparam int LANES = W / 8;

    logic [W-1:0] nxt;
    logic         step_taken;

    assign step_taken = step && !clr && !(|lane_we);

    always_comb begin
        nxt = q;
        if (clr) begin
            nxt = '0;
        end else if (|lane_we) begin
            for (int g = 0; g < LANES; g++) begin
                if (lane_we[g]) nxt[8*g +: 8] = wdata;
            end
        end else if (step) begin
            if (DOWN) nxt = q - W'(1);
            else      nxt = q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign hit_zero = step_taken && DOWN && (q == W'(1));
    assign wrapped  = step_taken && (DOWN ? (q == '0) : (&q));

endmodule

// File: rtl/xfer_status.sv
module xfer_status
    import xfer_track_pkg::*;
#(
    parameter int NF = N_FLAGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_vec,
    input  logic          clr_we,
    input  logic          en_we,
    input  logic [NF-1:0] wbits,
    output logic [NF-1:0] stat,
    output logic [NF-1:0] en,
    output logic          irq
);
    logic [NF-1:0] clr_mask;

    assign clr_mask = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= (stat & ~clr_mask) | set_vec;
            if (en_we) en <= wbits;
            irq  <= |(stat & en);
        end
    end

endmodule

// File: rtl/xfer_track.sv
module xfer_track
    import xfer_track_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int ADR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              xfer_commit,
    output logic              irq
);
    localparam int CNT_LANES = CNT_W / 8;
    localparam int ADR_LANES = ADR_W / 8;

    reg_req_t               req;
    logic [CNT_LANES-1:0]   cnt_we;
    logic [ADR_LANES-1:0]   adr_we;
    logic [CNT_W-1:0]       cnt_q;
    logic [ADR_W-1:0]       adr_q;
    logic [N_FLAGS-1:0]     stat_q;
    logic [N_FLAGS-1:0]     en_q;
    logic [N_FLAGS-1:0]     set_vec;
    logic                   cnt_clr;
    logic                   cnt_zero;
    logic                   cnt_wrap;
    logic                   adr_zero_unused;
    logic                   adr_wrap_unused;

    assign req = '{addr: reg_addr, wr: reg_wr, wdata: reg_wdata};

    for (genvar g = 0; g < CNT_LANES; g++) begin : g_cnt_dec
        assign cnt_we[g] = req.wr && ofs_match(req.addr, OFS_CNT + g);
    end
    for (genvar g = 0; g < ADR_LANES; g++) begin : g_adr_dec
        assign adr_we[g] = req.wr && ofs_match(req.addr, OFS_ADR + g);
    end

    assign cnt_clr = req.wr && ofs_match(req.addr, OFS_CTL) && req.wdata[0];

    xfer_byte_counter #(.W(CNT_W), .DOWN(1'b1)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .lane_we  (cnt_we),
        .wdata    (req.wdata),
        .clr      (cnt_clr),
        .step     (xfer_commit),
        .q        (cnt_q),
        .hit_zero (cnt_zero),
        .wrapped  (cnt_wrap)
    );

    xfer_byte_counter #(.W(ADR_W), .DOWN(1'b0)) u_adr (
        .clk      (clk),
        .rst      (rst),
        .lane_we  (adr_we),
        .wdata    (req.wdata),
        .clr      (1'b0),
        .step     (xfer_commit),
        .q        (adr_q),
        .hit_zero (adr_zero_unused),
        .wrapped  (adr_wrap_unused)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_DONE] = cnt_zero;
        set_vec[FLAG_WRAP] = cnt_wrap;
    end

    xfer_status #(.NF(N_FLAGS)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_we  (req.wr && ofs_match(req.addr, OFS_STAT)),
        .en_we   (req.wr && ofs_match(req.addr, OFS_IEN)),
        .wbits   (req.wdata[N_FLAGS-1:0]),
        .stat    (stat_q),
        .en      (en_q),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < CNT_LANES; g++) begin
            if (ofs_match(req.addr, OFS_CNT + g)) reg_rdata = cnt_q[8*g +: 8];
        end
        for (int g = 0; g < ADR_LANES; g++) begin
            if (ofs_match(req.addr, OFS_ADR + g)) reg_rdata = adr_q[8*g +: 8];
        end
        if (ofs_match(req.addr, OFS_STAT)) reg_rdata = BYTE_W'(stat_q);
        if (ofs_match(req.addr, OFS_IEN))  reg_rdata = BYTE_W'(en_q);
    end

endmodule

// File: rtl/xfer_track_chk.sv
module xfer_track_chk
    import xfer_track_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int ADR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [BYTE_W-1:0]  reg_wdata,
    input logic               xfer_commit,
    input logic               irq,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [ADR_W-1:0]   adr_q,
    input logic [N_FLAGS-1:0] stat_q,
    input logic [N_FLAGS-1:0] en_q
);
    logic cnt_hit;
    logic adr_hit;
    logic ctl_clr;

    assign ctl_clr = reg_wr && (reg_addr == REG_AW'(OFS_CTL)) && reg_wdata[0];
    assign cnt_hit = (reg_wr && (reg_addr < REG_AW'(OFS_CNT + CNT_W / 8))) || ctl_clr;
    assign adr_hit = reg_wr && (reg_addr >= REG_AW'(OFS_ADR))
                            && (reg_addr < REG_AW'(OFS_ADR + ADR_W / 8));

    assert_count_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_commit && !cnt_hit) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!xfer_commit && !cnt_hit) |=> $stable(cnt_q));

    assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_commit && !cnt_hit && cnt_q == CNT_W'(1)) |=> stat_q[FLAG_DONE]);

    assert_wrap_set_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_commit && !cnt_hit && cnt_q == '0) |=> (stat_q[FLAG_WRAP] && (&cnt_q)));

    assert_addr_inc_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_commit && !adr_hit) |=> (adr_q == ADR_W'($past(adr_q) + ADR_W'(1))));

    assert_ctl_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_clr |=> (cnt_q == '0));

    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(stat_q) & $past(en_q))));

endmodule

bind xfer_track xfer_track_chk #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .xfer_commit (xfer_commit),
    .irq         (irq),
    .cnt_q       (cnt_q),
    .adr_q       (adr_q),
    .stat_q      (stat_q),
    .en_q        (en_q)
);

// File: tb/sim_xfer_track.sv
`timescale 1ns/1ps
module sim_xfer_track;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       xfer_commit = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    typedef struct {
        bit       is_irq;
        logic [7:0] exp;
        string    tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    xfer_track u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_commit(xfer_commit), .irq(irq)
    );

    // monitor: pops expected items and compares with the live outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'd0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic op(input bit wr, input logic [3:0] a, input logic [7:0] d, input bit commit);
        @(posedge clk); #1;
        reg_wr = wr; reg_addr = a; reg_wdata = d; xfer_commit = commit;
        @(posedge clk); #1;
        reg_wr = 1'b0; xfer_commit = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        op(1'b1, a, d, 1'b0);
    endtask

    task automatic commit_n(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 4'h0, 8'h00, 1'b1);
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input bit exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {7'd0, exp}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_cnt(input logic [23:0] v, input string tag);
        for (int g = 0; g < 3; g++) expect_rd(4'(g), v[8*g +: 8], tag);
    endtask

    task automatic expect_adr(input logic [31:0] v, input string tag);
        for (int g = 0; g < 4; g++) expect_rd(4'(4 + g), v[8*g +: 8], tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_cnt(24'h0, "R1 count");
        expect_adr(32'h0, "R1 address");
        expect_rd(4'h8, 8'h00, "R1 status");
        expect_rd(4'h9, 8'h00, "R1 enable");
        expect_irq(1'b0, "R1 irq");

        // R2/R3/R5: count down to zero, address carry
        wr(4'h0, 8'h03); wr(4'h1, 8'h00); wr(4'h2, 8'h00);
        wr(4'h4, 8'hFE); wr(4'h5, 8'hFF); wr(4'h6, 8'h00); wr(4'h7, 8'h00);
        wr(4'h9, 8'h01);
        commit_n(2);
        expect_cnt(24'h000001, "R2 count after two commits");
        expect_rd(4'h8, 8'h00, "R3 done not yet set");
        commit_n(1);
        expect_cnt(24'h000000, "R2 count at zero");
        expect_rd(4'h8, 8'h01, "R3 done set");
        expect_adr(32'h0001_0001, "R5 address carry");
        expect_irq(1'b1, "R8 irq from enabled done");

        // R6 write-one-to-clear per bit
        wr(4'h8, 8'h02);
        expect_rd(4'h8, 8'h01, "R6 zero bit keeps done");
        wr(4'h8, 8'h01);
        expect_rd(4'h8, 8'h00, "R6 done cleared");
        expect_irq(1'b0, "R8 irq drops");

        // R4 wrap from zero; R8 masking
        commit_n(1);
        expect_cnt(24'hFFFFFF, "R4 count wraps");
        expect_rd(4'h8, 8'h02, "R4 wrap set, done clear");
        expect_irq(1'b0, "R8 wrap masked");
        wr(4'h9, 8'h02);
        expect_irq(1'b1, "R8 wrap enabled");
        wr(4'h8, 8'h02);

        // R9 count byte write beats commit; address still steps
        op(1'b1, 4'h1, 8'h55, 1'b1);
        expect_cnt(24'hFF55FF, "R9 write wins over step");
        expect_rd(4'h8, 8'h00, "R9 no flag");
        expect_adr(32'h0001_0003, "R9 address steps");

        // R9/R5 address byte write beats address step; count steps
        op(1'b1, 4'h4, 8'h80, 1'b1);
        expect_adr(32'h0001_0080, "R5 address write wins");
        expect_cnt(24'hFF55FE, "R2 count steps");

        // R7 control clear beats commit
        op(1'b1, 4'hA, 8'h01, 1'b1);
        expect_cnt(24'h000000, "R7 clear");
        expect_rd(4'h8, 8'h00, "R7 no wrap on cleared step");
        expect_rd(4'hA, 8'h00, "R7 control reads zero");

        // R6 set beats clear in same cycle
        wr(4'h0, 8'h01);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 8'h01; xfer_commit = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; xfer_commit = 1'b0;
        expect_rd(4'h8, 8'h01, "R6 set wins over clear");
        wr(4'h8, 8'h03);

        // R2 borrow across bytes
        wr(4'h0, 8'h00); wr(4'h1, 8'h00); wr(4'h2, 8'h01);
        commit_n(1);
        expect_cnt(24'h00FFFF, "R2 borrow");
        commit_n(3);
        expect_cnt(24'h00FFFC, "R2 consecutive commits");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule